// File: doc/BRIEF.md
# Two-Wide Category-Paired Issue Dispatcher

This block is the issue stage of an in-order core that can start two instructions per cycle on four single-unit execution pipes: integer, load/store, branch and floating-point. Instructions reach it already classified into an issue category. Each one also carries an opaque payload. They are pushed into a four-entry queue. Every cycle the two oldest queued entries are examined. The block issues both, only the oldest, or nothing, and steers each issued entry onto exactly one pipe. Each pipe has its own ready signal.

Two categories need special handling. A register or immediate move can run on either the integer or the load/store pipe. A move can therefore pair with integer work, with memory work, and even with another move. A serializing category always issues alone. Issue never goes out of order. A younger entry that cannot go with its elder moves to the head of the queue and is paired again on the next cycle. A flush input empties the queue in one cycle.

Top module: `pair_dispatcher`

## Requirements
- R1: While reset is held and right after it, the queue is empty. `push_ready` is 1, no `pipe_valid` bit is set, and `issue_count` is 0.
- R2: The queue holds up to DEPTH (default 4) entries in arrival order. A push is accepted when `push_valid` is 1, `flush` is 0 and fewer than DEPTH entries are held. `push_ready` is 0 exactly when DEPTH entries are held.
- R3: Category codes are 0 move, 1 integer, 2 load/store, 3 branch, 4 floating-point, and 5 to 7 serializing. Pipe indices are 0 integer, 1 load/store, 2 branch and 3 floating-point. Categories 1 to 4 always use pipe index code minus 1. Serializing entries use pipe 0.
- R4: The oldest entry issues only when its pipe is ready. The younger entry never issues unless the oldest issues in the same cycle.
- R5: The two head entries issue together when both pipes are ready and they target different pipes. Neither of them may be serializing.
- R6: A move at the head prefers pipe 0, or pipe 1 when the entry behind it is an integer instruction. It falls back to the other of the two pipes when the preferred one is not ready. A move in the second slot takes pipe 1 if the head took pipe 0, and pipe 0 otherwise.
- R7: A serializing entry never issues in the same cycle as any other entry, whether it is the older or the younger of the two.
- R8: `issue_count` equals the number of set `pipe_valid` bits. Each issued entry's payload appears on its pipe's `pipe_payload`.
- R9: While `flush` is 1 nothing issues and the push is dropped. The queue is empty on the next cycle.
- R10: Issued entries leave the queue at the clock edge. A younger entry that did not issue is the head on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue, suppress issue this cycle |
| push_valid | input | 1 | New instruction offered |
| push_cat | input | 3 | Issue category of the offered instruction |
| push_payload | input | PW | Opaque payload of the offered instruction |
| push_ready | output | 1 | Queue has a free entry |
| pipe_ready | input | 4 | Per-pipe ready (0 int, 1 ld/st, 2 branch, 3 fp) |
| pipe_valid | output | 4 | Per-pipe issue strobe |
| pipe_payload | output | 4 x PW | Per-pipe payload of the issued instruction |
| issue_count | output | 2 | Instructions issued this cycle (0, 1 or 2) |

## Verification
The hardest case to reach is a move at the head that must give up its preferred pipe. This happens because that pipe is stalled, or because an integer entry follows it. The fallback choice then decides whether the younger entry can still go. Reaching it needs a full queue of moves and integer or memory entries while the integer and load/store readies toggle independently. So one stimulus phase restricts categories to those three, another randomizes each ready bit separately, and a cycle-level queue model in the bench checks every pipe output on every clock.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int CAT_W  = 3;
  localparam int NPIPE  = 4;
  localparam int SEL_W  = 2;

  localparam logic [CAT_W-1:0] CAT_MOV = 3'd0;
  localparam logic [CAT_W-1:0] CAT_ALU = 3'd1;
  localparam logic [CAT_W-1:0] CAT_MEM = 3'd2;
  localparam logic [CAT_W-1:0] CAT_BRN = 3'd3;
  localparam logic [CAT_W-1:0] CAT_FPU = 3'd4;

  localparam logic [SEL_W-1:0] PIPE_INT = 2'd0;
  localparam logic [SEL_W-1:0] PIPE_LS  = 2'd1;
  localparam logic [SEL_W-1:0] PIPE_BR  = 2'd2;
  localparam logic [SEL_W-1:0] PIPE_FP  = 2'd3;

  // serializing: every code above floating-point
  function automatic logic is_solo(input logic [CAT_W-1:0] c);
    return c > CAT_FPU;
  endfunction

  // pipe for categories with a single home; moves resolved elsewhere
  function automatic logic [SEL_W-1:0] home_pipe(input logic [CAT_W-1:0] c);
    case (c)
      CAT_MEM: return PIPE_LS;
      CAT_BRN: return PIPE_BR;
      CAT_FPU: return PIPE_FP;
      default: return PIPE_INT;
    endcase
  endfunction
endpackage

// File: rtl/iq_fifo.sv
module iq_fifo
  import dispatch_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_valid,
  input  logic [CAT_W-1:0] push_cat,
  input  logic [PW-1:0]    push_pay,
  output logic             push_ready,
  input  logic [1:0]       pop_cnt,
  output logic             h0_vld,
  output logic             h1_vld,
  output logic [CAT_W-1:0] h0_cat,
  output logic [CAT_W-1:0] h1_cat,
  output logic [PW-1:0]    h0_pay,
  output logic [PW-1:0]    h1_pay
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W:0]   DEPTH_P = (PTR_W+1)'(DEPTH);
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(DEPTH);

  logic [CAT_W-1:0] cat_q [DEPTH];
  logic [PW-1:0]    pay_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_n, wr_q, wr_n, rd_nxt1;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             push_ok;

  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                input logic [1:0] inc);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (PTR_W+1)'(inc);
    if (s >= DEPTH_P) s = s - DEPTH_P;
    return s[PTR_W-1:0];
  endfunction

  assign push_ready = (cnt_q != FULL_C);
  assign push_ok    = push_valid && push_ready && !flush;
  assign rd_nxt1    = wrap_add(rd_q, 2'd1);
  assign h0_vld     = (cnt_q != '0);
  assign h1_vld     = (cnt_q > CNT_W'(1));
  assign h0_cat     = cat_q[rd_q];
  assign h0_pay     = pay_q[rd_q];
  assign h1_cat     = cat_q[rd_nxt1];
  assign h1_pay     = pay_q[rd_nxt1];

  always_comb begin
    if (flush) begin
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else begin
      rd_n  = wrap_add(rd_q, pop_cnt);
      wr_n  = wrap_add(wr_q, {1'b0, push_ok});
      cnt_n = cnt_q - CNT_W'(pop_cnt) + CNT_W'(push_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wen;
    assign wen = push_ok && (wr_q == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cat_q[i] <= '0;
        pay_q[i] <= '0;
      end else if (wen) begin
        cat_q[i] <= push_cat;
        pay_q[i] <= push_pay;
      end
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_C);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
  a_r10_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(pop_cnt) <= cnt_q);
endmodule

// File: rtl/pair_decider.sv
module pair_decider
  import dispatch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             v0,
  input  logic             v1,
  input  logic [CAT_W-1:0] c0,
  input  logic [CAT_W-1:0] c1,
  input  logic [NPIPE-1:0] pipe_rdy,
  output logic             issue0,
  output logic             issue1,
  output logic [SEL_W-1:0] sel0,
  output logic [SEL_W-1:0] sel1,
  output logic [1:0]       issue_cnt
);
  logic [SEL_W-1:0] pref, alt;

  always_comb begin
    // a move in front of integer work leaves the integer pipe free
    if (v1 && c1 == CAT_ALU) begin
      pref = PIPE_LS;
      alt  = PIPE_INT;
    end else begin
      pref = PIPE_INT;
      alt  = PIPE_LS;
    end
    if (c0 == CAT_MOV) begin
      if (pipe_rdy[pref])     sel0 = pref;
      else if (pipe_rdy[alt]) sel0 = alt;
      else                    sel0 = pref;
    end else begin
      sel0 = home_pipe(c0);
    end
    issue0 = v0 && !hold && pipe_rdy[sel0];

    if (c1 == CAT_MOV) sel1 = (sel0 == PIPE_INT) ? PIPE_LS : PIPE_INT;
    else               sel1 = home_pipe(c1);
    issue1 = issue0 && v1 && !is_solo(c0) && !is_solo(c1) &&
             (sel1 != sel0) && pipe_rdy[sel1];

    issue_cnt = {1'b0, issue0} + {1'b0, issue1};
  end

  a_r7_solo_alone: assert property (@(posedge clk) disable iff (!rst_n)
    ((v0 && is_solo(c0)) || (v1 && is_solo(c1))) |-> (issue_cnt <= 2'd1));
endmodule

// File: rtl/issue_router.sv
module issue_router
  import dispatch_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic                       issue0,
  input  logic                       issue1,
  input  logic [SEL_W-1:0]           sel0,
  input  logic [SEL_W-1:0]           sel1,
  input  logic [PW-1:0]              pay0,
  input  logic [PW-1:0]              pay1,
  output logic [NPIPE-1:0]           pipe_vld,
  output logic [NPIPE-1:0][PW-1:0]   pipe_data
);
  for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
    logic hit0, hit1;
    assign hit0 = issue0 && (sel0 == SEL_W'(g));
    assign hit1 = issue1 && (sel1 == SEL_W'(g));
    always_comb begin
      pipe_vld[g] = hit0 || hit1;
      if (hit0)      pipe_data[g] = pay0;
      else if (hit1) pipe_data[g] = pay1;
      else           pipe_data[g] = '0;
    end
  end
endmodule

// File: rtl/pair_dispatcher.sv
module pair_dispatcher
  import dispatch_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push_valid,
  input  logic [2:0]               push_cat,
  input  logic [PW-1:0]            push_payload,
  output logic                     push_ready,
  input  logic [3:0]               pipe_ready,
  output logic [3:0]               pipe_valid,
  output logic [3:0][PW-1:0]       pipe_payload,
  output logic [1:0]               issue_count
);
  logic             h0_vld, h1_vld;
  logic [CAT_W-1:0] h0_cat, h1_cat;
  logic [PW-1:0]    h0_pay, h1_pay;
  logic             iss0, iss1;
  logic [SEL_W-1:0] sel0, sel1;

  iq_fifo #(.DEPTH(DEPTH), .PW(PW)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_valid(push_valid), .push_cat(push_cat), .push_pay(push_payload),
    .push_ready(push_ready), .pop_cnt(issue_count),
    .h0_vld(h0_vld), .h1_vld(h1_vld), .h0_cat(h0_cat), .h1_cat(h1_cat),
    .h0_pay(h0_pay), .h1_pay(h1_pay)
  );

  pair_decider u_pair (
    .clk(clk), .rst_n(rst_n), .hold(flush),
    .v0(h0_vld), .v1(h1_vld), .c0(h0_cat), .c1(h1_cat),
    .pipe_rdy(pipe_ready), .issue0(iss0), .issue1(iss1),
    .sel0(sel0), .sel1(sel1), .issue_cnt(issue_count)
  );

  issue_router #(.PW(PW)) u_route (
    .issue0(iss0), .issue1(iss1), .sel0(sel0), .sel1(sel1),
    .pay0(h0_pay), .pay1(h1_pay),
    .pipe_vld(pipe_valid), .pipe_data(pipe_payload)
  );

  a_r4_ready_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_valid & ~pipe_ready) == 4'b0);
  a_r8_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pipe_valid) == int'(issue_count));
  a_r9_no_issue_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (pipe_valid == 4'b0));
endmodule

// File: tb/tb_pair_dispatcher.sv
`timescale 1ns/1ps
module tb_pair_dispatcher;
  localparam int PW = 16;

  logic              clk;
  logic              rst_n;
  logic              flush;
  logic              push_valid;
  logic [2:0]        push_cat;
  logic [PW-1:0]     push_payload;
  logic              push_ready;
  logic [3:0]        pipe_ready;
  logic [3:0]        pipe_valid;
  logic [3:0][PW-1:0] pipe_payload;
  logic [1:0]        issue_count;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  pair_dispatcher #(.DEPTH(4), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_valid(push_valid),
    .push_cat(push_cat), .push_payload(push_payload), .push_ready(push_ready),
    .pipe_ready(pipe_ready), .pipe_valid(pipe_valid),
    .pipe_payload(pipe_payload), .issue_count(issue_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // behavioural queue model
  int qc[$];
  int qp[$];
  int ev[4];
  int ed[4];
  int ecount, op, yp, first, c0, c1, sz, rdy_pct, cat_max;
  bit fl, pv, prev_partial;
  int pcat, ppay;
  string scen, ptag;

  initial begin
    rst_n = 1'b0; flush = 1'b0; push_valid = 1'b0;
    push_cat = '0; push_payload = '0; pipe_ready = 4'hF;
    prev_partial = 0;
    repeat (3) @(negedge clk);
    #5;
    chk("R1 push_ready in reset", int'(push_ready), 1);
    chk("R1 pipe_valid in reset", int'(pipe_valid), 0);
    chk("R1 issue_count in reset", int'(issue_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 pipe_valid after reset", int'(pipe_valid), 0);
    chk("R1 push_ready after reset", int'(push_ready), 1);

    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      if (cyc < 2000)      begin rdy_pct = 75;  cat_max = 8; end
      else if (cyc < 4000) begin rdy_pct = 100; cat_max = 3; end
      else                 begin rdy_pct = 50;  cat_max = 8; end
      fl   = (($urandom % 35) == 0);
      pv   = (($urandom % 5) != 0);
      pcat = int'($urandom % cat_max);
      ppay = int'($urandom % 65536);
      for (int g = 0; g < 4; g++)
        pipe_ready[g] = (int'($urandom % 100) < rdy_pct);
      if (cyc >= 2000 && cyc < 4000 && (cyc % 7) < 3)
        pipe_ready[$urandom % 2] = 1'b0;
      flush = fl;
      push_valid = pv;
      push_cat = 3'(pcat);
      push_payload = PW'(ppay);
      #5;

      for (int g = 0; g < 4; g++) begin ev[g] = 0; ed[g] = 0; end
      ecount = 0;
      op = -1;
      sz = qc.size();
      if (!fl && sz >= 1) begin
        c0 = qc[0];
        if (c0 == 0) begin
          first = (sz >= 2 && qc[1] == 1) ? 1 : 0;
          if (pipe_ready[first]) op = first;
          else if (pipe_ready[1-first]) op = 1 - first;
        end else begin
          first = (c0 >= 5) ? 0 : c0 - 1;
          if (pipe_ready[first]) op = first;
        end
        if (op >= 0) begin
          ev[op] = 1; ed[op] = qp[0]; ecount = 1;
          if (sz >= 2 && c0 < 5 && qc[1] < 5) begin
            c1 = qc[1];
            yp = (c1 == 0) ? ((op == 0) ? 1 : 0) : c1 - 1;
            if (yp != op && pipe_ready[yp]) begin
              ev[yp] = 1; ed[yp] = qp[1]; ecount = 2;
            end
          end
        end
      end

      if (fl) scen = "R9";
      else if (sz >= 1 && (qc[0] >= 5 || (sz >= 2 && qc[1] >= 5))) scen = "R7";
      else if (sz >= 1 && (qc[0] == 0 || (sz >= 2 && qc[1] == 0))) scen = "R6";
      else if (ecount == 2) scen = "R5";
      else scen = "R4";
      ptag = prev_partial ? "R10 head advance pipe" : "R3 pipe map";

      chk({"R8 count ", scen}, int'(issue_count), ecount);
      for (int g = 0; g < 4; g++) begin
        chk({ptag, " valid ", scen}, int'(pipe_valid[g]), ev[g]);
        if (ev[g] != 0)
          chk({"R8 payload ", scen}, int'(pipe_payload[g]), ed[g]);
      end
      chk("R2 push_ready", int'(push_ready), (sz < 4) ? 1 : 0);

      if (fl) begin
        qc.delete(); qp.delete();
      end else begin
        for (int k = 0; k < ecount; k++) begin
          void'(qc.pop_front()); void'(qp.pop_front());
        end
        if (pv && sz < 4) begin qc.push_back(pcat); qp.push_back(ppay); end
      end
      prev_partial = !fl && ecount == 1 && sz >= 2;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule